// File: doc/BRIEF.md
# Vectored Interrupt Receiver

This block gathers a bank of level-sensitive device interrupt lines and presents them to a processor core as one vectored interrupt. Every clock it compares each line with the value it held on the previous clock. A line that goes from low to high is a request. A line that goes from high to low is a withdrawal.

The block has a single receive buffer, guarded by a busy flag. A request is taken only while the buffer is free. When it is taken, the block stores a three-word packet that names the line, sets busy, raises the interrupt request level toward the core and gives a one-cycle wake pulse. A request that arrives while the buffer is held is dropped and is never replayed. A fall on any line while busy is set frees the buffer and drops the request. It does not matter which line set busy.

Software reads the status word and the three data words through a small combinational read port.

Top module: `ivr_receiver`

## Requirements
- R1: While reset is held and on the first clock after it, irqReq and wakeOut are 0 and all four readable words (status and data words 0, 1, 2) read as zero.
- R2: A line whose sampled value goes from 0 to 1 while busy is clear is accepted at that clock edge. From then on irqReq is 1 and bit 5 of the status word (read address 0) is 1. All other status bits stay 0.
- R3: On acceptance, data word 0 (read address 1) becomes 0x7C0 ORed with the accepted line index. That puts 5'h1F in bits 10:6 and the index in bits 5:0.
- R4: On acceptance, data words 1 and 2 (read addresses 2 and 3) become zero.
- R5: wakeOut is 1 for exactly the one cycle that follows each acceptance, and irqReq is 1 in that cycle.
- R6: A rising line while busy is set is ignored: busy, irqReq and data word 0 keep their values, and wakeOut stays 0.
- R7: While busy is set, a 1-to-0 transition on any line clears busy and irqReq at that clock edge, whichever line was accepted.
- R8: A falling line while busy is clear changes nothing: irqReq, wakeOut, the status word and data word 0 keep their values.
- R9: When several lines rise on the same clock while the buffer is free, only the lowest-numbered one is accepted.
- R10: When a fall and a rise come on the same clock while busy is set, the fall clears busy first. The rise is then accepted, so busy stays 1, data word 0 takes the new index and wakeOut pulses.
- R11: The read port maps rdAddr 0 to status, 1 to data word 0, 2 to data word 1 and 3 to data word 2. rdData follows rdAddr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lines | input | NUM_LINES | Level interrupt lines, synchronous to clk |
| rdAddr | input | 2 | Read select: 0 status, 1..3 data words 0..2 |
| rdData | output | DATA_W | Selected word |
| irqReq | output | 1 | Interrupt request level toward the core |
| wakeOut | output | 1 | One-cycle pulse that wakes a halted core |

## Verification
The bench builds the block with its defaults: 64 lines and 64-bit words. With these values the top index, 63, fills the whole six-bit index field, so data word 0 reaches 0x7FF. The bench also raises low, middle and top lines in the same cycle to exercise the lowest-index choice across the full encoder width. A scoreboard predicts busy and word 0 for every driven pattern. The patterns cover a rise and a fall on the same clock, and falls on lines other than the accepted one.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int IDX_MAX_W = 16;
  localparam int BUSY_BIT  = 5;
  localparam int TAG_LSB   = 6;
  localparam logic [4:0] TAG_VALUE = 5'h1F;

  typedef enum logic [1:0] {
    RD_STATUS = 2'd0,
    RD_WORD0  = 2'd1,
    RD_WORD1  = 2'd2,
    RD_WORD2  = 2'd3
  } rdSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic                 capture;
    logic [IDX_MAX_W-1:0] lineIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/ivr_edge.sv
module ivr_edge #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lines,
  output logic [NUM_LINES-1:0] riseVec,
  output logic [NUM_LINES-1:0] fallVec
);
  logic [NUM_LINES-1:0] prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= lines;
  end

  assign riseVec = lines & ~prevQ;
  assign fallVec = ~lines & prevQ;
endmodule

// File: rtl/ivr_ctrl.sv
module ivr_ctrl
  import ivr_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] riseVec,
  input  logic [NUM_LINES-1:0] fallVec,
  output logic                 busy,
  output ctrlStrobes_t         strobes
);
  logic anyRise, anyFall, busyAfterFall;
  logic [IDX_MAX_W-1:0] lowIdx;

  assign anyRise = |riseVec;
  assign anyFall = |fallVec;
  // a fall is applied before a rise in the same cycle
  assign busyAfterFall = busy & ~anyFall;

  // lowest-numbered rising line wins
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (riseVec[i]) lowIdx = IDX_MAX_W'(i);
    end
  end

  always_comb begin
    strobes.capture = anyRise & ~busyAfterFall;
    strobes.lineIdx = lowIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                busy <= 1'b0;
    else if (strobes.capture) busy <= 1'b1;
    else                      busy <= busyAfterFall;
  end

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    busy && !anyFall |-> !strobes.capture); // R6
  AST_FALL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    busy && anyFall && !anyRise |=> !busy); // R7
  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rstN)
    !busy && !anyRise |=> !busy); // R8
  AST_FALL_THEN_RISE: assert property (@(posedge clk) disable iff (!rstN)
    busy && anyFall && anyRise |=> busy); // R10
endmodule

// File: rtl/ivr_datapath.sv
module ivr_datapath
  import ivr_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              busy,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              wakeOut
);
  localparam logic [DATA_W-1:0] TAG_WORD = DATA_W'(TAG_VALUE) << TAG_LSB;

  logic [DATA_W-1:0] word0, word1, word2, statusWord;
  logic              wakeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word0 <= '0;
      word1 <= '0;
      word2 <= '0;
      wakeQ <= 1'b0;
    end else begin
      wakeQ <= strobes.capture;
      if (strobes.capture) begin
        word0 <= TAG_WORD | DATA_W'(strobes.lineIdx);
        word1 <= '0;
        word2 <= '0;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[BUSY_BIT] = busy;
  end

  always_comb begin
    unique case (rdSel_e'(rdAddr))
      RD_STATUS: rdData = statusWord;
      RD_WORD0:  rdData = word0;
      RD_WORD1:  rdData = word1;
      default:   rdData = word2;
    endcase
  end

  assign wakeOut = wakeQ;

  AST_WAKE_WITH_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    wakeQ |-> busy); // R5
  AST_WORD0_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> word0 == (TAG_WORD | DATA_W'($past(strobes.lineIdx)))); // R3
  AST_WORDS_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> word1 == '0 && word2 == '0); // R4
endmodule

// File: rtl/ivr_receiver.sv
module ivr_receiver
  import ivr_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int DATA_W    = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lines,
  input  logic [1:0]           rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqReq,
  output logic                 wakeOut
);
  logic [NUM_LINES-1:0] riseVec, fallVec;
  logic                 busy;
  ctrlStrobes_t         strobes;

  ivr_edge #(.NUM_LINES(NUM_LINES)) i_edge (
    .clk(clk), .rstN(rstN), .lines(lines),
    .riseVec(riseVec), .fallVec(fallVec)
  );

  ivr_ctrl #(.NUM_LINES(NUM_LINES)) i_ctrl (
    .clk(clk), .rstN(rstN), .riseVec(riseVec), .fallVec(fallVec),
    .busy(busy), .strobes(strobes)
  );

  ivr_datapath #(.DATA_W(DATA_W)) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy),
    .rdAddr(rdAddr), .rdData(rdData), .wakeOut(wakeOut)
  );

  assign irqReq = busy;
endmodule

// File: tb/test_ivr_receiver.sv
`timescale 1ns/100ps
module test_ivr_receiver;
  localparam int L = 64;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [L-1:0] lines = '0;
  logic [1:0]   rdAddr = 2'd0;
  logic [W-1:0] rdData;
  logic         irqReq, wakeOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic         busy;
    logic         wake;
    logic [W-1:0] w0;
  } expItem_t;

  expItem_t expQ[$];
  string    tagQ[$];

  logic [L-1:0] mPrev = '0;
  logic         mBusy = 1'b0;
  logic [W-1:0] mW0 = '0;

  ivr_receiver #(.NUM_LINES(L), .DATA_W(W)) i_ivr_receiver (
    .clk(clk), .rstN(rstN), .lines(lines), .rdAddr(rdAddr),
    .rdData(rdData), .irqReq(irqReq), .wakeOut(wakeOut)
  );

  always #5 clk = ~clk;

  // driver: apply a pattern and push the prediction
  task automatic drive(input logic [L-1:0] v, input string tag);
    logic [L-1:0] rise, fall;
    logic wake;
    rise = v & ~mPrev;
    fall = ~v & mPrev;
    wake = 1'b0;
    if (mBusy && (|fall)) mBusy = 1'b0;            // R7, R10: fall first
    if ((|rise) && !mBusy) begin                    // R2
      for (int i = L - 1; i >= 0; i--)              // R9: lowest wins
        if (rise[i]) mW0 = 64'h7C0 | W'(i);         // R3
      mBusy = 1'b1;
      wake = 1'b1;                                  // R5
    end
    mPrev = v;
    @(negedge clk);
    lines = v;
    expQ.push_back('{busy: mBusy, wake: wake, w0: mW0});
    tagQ.push_back(tag);
  endtask

  task automatic readAll(output logic [W-1:0] s, output logic [W-1:0] a,
                         output logic [W-1:0] b, output logic [W-1:0] c);
    rdAddr = 2'd0; #1 s = rdData;
    rdAddr = 2'd1; #1 a = rdData;
    rdAddr = 2'd2; #1 b = rdData;
    rdAddr = 2'd3; #1 c = rdData;
  endtask

  // monitor: compare after each edge that consumed a pattern
  initial begin
    forever begin
      @(posedge clk);
      if (expQ.size() > 0) begin
        expItem_t e;
        string t;
        logic [W-1:0] s, a, b, c, es;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        #0.5;
        readAll(s, a, b, c);
        es = '0;
        es[5] = e.busy;
        checks++;
        if (irqReq !== e.busy || wakeOut !== e.wake || s !== es ||
            a !== e.w0 || b !== '0 || c !== '0) begin
          errors++;
          $display("FAIL %s: irq=%b wake=%b st=%h w0=%h w1=%h w2=%h expected irq=%b wake=%b st=%h w0=%h w1=0 w2=0",
                   t, irqReq, wakeOut, s, a, b, c, e.busy, e.wake, es, e.w0);
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    logic [W-1:0] s, a, b, c;
    repeat (3) @(negedge clk);
    #1;
    readAll(s, a, b, c);
    checks++;
    if (irqReq !== 1'b0 || wakeOut !== 1'b0 || s !== '0 || a !== '0 ||
        b !== '0 || c !== '0) begin
      errors++;
      $display("FAIL R1 reset: irq=%b wake=%b st=%h w0=%h w1=%h w2=%h expected all zero",
               irqReq, wakeOut, s, a, b, c);
    end
    @(negedge clk);
    rstN = 1'b1;
    drive('0, "R1 idle after reset");
    drive(L'(1) << 5, "R2 R3 R4 R5 R11 accept line 5");
    drive(L'(1) << 5, "R5 wake single cycle");
    drive((L'(1) << 5) | (L'(1) << 9), "R6 rise while busy");
    drive(L'(1) << 5, "R7 fall of other line clears");
    drive('0, "R8 fall while idle");
    drive((L'(1) << 12) | (L'(1) << 40) | (L'(1) << 63), "R9 lowest of three");
    drive((L'(1) << 40) | (L'(1) << 63), "R7 fall of captured line");
    drive((L'(1) << 40) | (L'(1) << 63) | (L'(1) << 2), "R2 accept line 2");
    drive((L'(1) << 63) | (L'(1) << 2) | (L'(1) << 7), "R10 fall and rise together");
    drive((L'(1) << 63) | (L'(1) << 2) | (L'(1) << 7), "R5 hold after R10");
    drive('0, "R7 all lines fall");
    drive(L'(1) << 63, "R3 top index 63");
    drive(L'(1) << 63, "R6 hold busy");
    drive('0, "R7 release top");
    drive(L'(1) << 0, "R3 index zero");
    drive('0, "R7 release zero");
    @(negedge clk);
    @(negedge clk);
    finish();
  end
endmodule